// File: doc/BRIEF.md
# GPIO interrupt channel multiplexer

This block connects a wide bank of pad inputs to a small number of interrupt lines that feed a downstream controller able to accept only active-high levels and rising edges. Each channel uses a programmable index to choose one pad. The chosen pad passes through a two-flop synchroniser. The channel can then invert the signal. A stability filter follows, and the channel then reports in either level form or single-pulse edge form. With the inversion, a low-active or falling-edge source can still reach an active-high sink.

Software programs four 32-bit words through a plain write port with byte enables. A combinational read path returns the word at the current address. A write that changes a channel's pad index, mode or inversion also reloads that channel's detector history. This reload stops the reconfiguration itself from creating an edge.

Top module: `gpio_irq_mux`

## Requirements
- R1: After reset, all four configuration words read as zero and every channel output is low. This means every channel selects pad 0, uses level mode, has no inversion and has no filter.
- R2: A write changes only the bytes whose byte-enable bit is set. Bit n of the enable covers data bits 8n+7..8n. A read returns the whole stored 32-bit word. The word index is the byte offset divided by 4: 0 is the mode word, 1 is the index word for channels 0..3, 2 is the index word for channels 4..7, and 3 is the filter word.
- R3: The 8-bit pad index of channel x is in word 1 for x<4 and in word 2 for x>=4, at bits (x mod 4)*8+7..(x mod 4)*8. In level mode without inversion, the channel output follows only the selected pad.
- R4: Bit 16+x of the mode word inverts channel x before detection. In level mode, an inverted channel is high while its pad is low.
- R5: Bit x of the mode word set to 1 puts channel x in edge mode. Each rising transition of the post-inversion signal then gives a high pulse of exactly one clock, and a falling transition gives none. With inversion, a falling pad edge gives the pulse.
- R6: The filter value N of channel x is in word 3 at bits 4x+3..4x. A change of the post-inversion signal reaches the detector only after it has been present for max(N,1) consecutive clocks. Counting from the first clock edge after the pad changes, the output responds after max(N,1)+2 edges. A pulse shorter than N clocks never reaches the output.
- R7: A write that changes channel x's index, edge bit or inversion bit reloads that channel's detector with the value now selected. No edge pulse results, even when the newly selected pad is already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, to be released synchronously |
| pad_i | input | NUM_PADS | Raw pad inputs (asynchronous) |
| wr_en_i | input | 1 | Write strobe for the addressed word |
| addr_i | input | 2 | Word index (byte offset / 4) |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte enables for the write |
| rdata_o | output | 32 | Stored word at addr_i |
| irq_o | output | NUM_CH | Active-high channel outputs |

## Verification
To check the index decode, every one of the 256 pad indices is routed through channel 0. All eight channels are also given distinct pads, and each pad is raised on its own. This shows that no channel follows a neighbouring pad or a neighbouring index byte. Each level and edge case runs both with and without inversion, which separates a missing inversion from a wrong detector. Filter depths 0, 1, 2, 5 and 15 each get a latency count. Pulses one clock shorter than the depth and exactly as long as the depth locate the filter threshold. For the reload, a pad that is already high is switched onto an edge-mode channel, and the bench looks for the spurious pulse that history left in place would cause.

// File: rtl/gim_pkg.sv
package gim_pkg;
  localparam int WORD_W  = 32;
  localparam int FILT_W  = 4;
  localparam int IDX_BW  = 8;
  localparam int NWORDS  = 4;

  // word indices (byte offset / 4)
  localparam logic [1:0] W_MODE  = 2'd0;
  localparam logic [1:0] W_IDXLO = 2'd1;
  localparam logic [1:0] W_IDXHI = 2'd2;
  localparam logic [1:0] W_FILT  = 2'd3;

  typedef struct packed {
    logic              edge_md;
    logic              inv;
    logic [IDX_BW-1:0] pad_idx;
    logic [FILT_W-1:0] filt;
  } chan_cfg_t;
endpackage

// File: rtl/gim_sync.sv
module gim_sync #(
  parameter int W = 256
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gim_regs.sv
module gim_regs
  import gim_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [3:0]        be_i,
  output logic [WORD_W-1:0] rdata_o,
  output chan_cfg_t         cfg_o [NUM_CH],
  output logic [NUM_CH-1:0] chg_o
);
  localparam int NBYTES = WORD_W / 8;
  localparam int PER_W  = WORD_W / IDX_BW;

  logic [WORD_W-1:0] word_q [NWORDS];
  logic [WORD_W-1:0] word_d [NWORDS];
  logic [NUM_CH-1:0] chg_d;
  logic [NUM_CH-1:0] chg_q;

  // next-state: byte-masked merge into the addressed word
  always_comb begin
    for (int w = 0; w < NWORDS; w++) begin
      word_d[w] = word_q[w];
      if (wr_en_i && (addr_i == w[1:0])) begin
        for (int b = 0; b < NBYTES; b++) begin
          if (be_i[b]) word_d[w][8*b +: 8] = wdata_i[8*b +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < NWORDS; w++) word_q[w] <= '0;
    end else if (wr_en_i) begin
      for (int w = 0; w < NWORDS; w++) word_q[w] <= word_d[w];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chg_q <= '0;
    else         chg_q <= chg_d;
  end

  for (genvar x = 0; x < NUM_CH; x++) begin : g_ch
    localparam int IW = 1 + x / PER_W;
    localparam int IB = (x % PER_W) * IDX_BW;
    assign cfg_o[x].edge_md = word_q[W_MODE][x];
    assign cfg_o[x].inv     = word_q[W_MODE][16 + x];
    assign cfg_o[x].pad_idx = word_q[IW][IB +: IDX_BW];
    assign cfg_o[x].filt    = word_q[W_FILT][FILT_W*x +: FILT_W];
    assign chg_d[x] = (word_d[W_MODE][x]      != word_q[W_MODE][x])
                    | (word_d[W_MODE][16 + x] != word_q[W_MODE][16 + x])
                    | (word_d[IW][IB +: IDX_BW] != word_q[IW][IB +: IDX_BW]);
  end

  assign rdata_o = word_q[addr_i];
  assign chg_o   = chg_q;

  // R2: a cleared byte enable leaves that byte of the mode word untouched
  p_be_masked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == W_MODE && !be_i[0])
      |=> (word_q[W_MODE][7:0] == $past(word_q[W_MODE][7:0])));
endmodule

// File: rtl/gim_channel.sv
module gim_channel
  import gim_pkg::*;
#(
  parameter int NUM_PADS = 256
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PADS-1:0] pads_i,
  input  chan_cfg_t           cfg_i,
  input  logic                resync_i,
  output logic                irq_o
);
  localparam int SEL_W = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;

  logic              sel_pad;
  logic              det_in;
  logic              stable_q, stable_d;
  logic              prev_q, prev_d;
  logic [FILT_W-1:0] cnt_q, cnt_d;
  logic              pulse;

  // pad selection and optional inversion
  always_comb begin
    sel_pad = 1'b0;
    if ({1'b0, cfg_i.pad_idx} < (IDX_BW+1)'(NUM_PADS))
      sel_pad = pads_i[cfg_i.pad_idx[SEL_W-1:0]];
    det_in = sel_pad ^ cfg_i.inv;
  end

  // stability filter and edge history, next state
  always_comb begin
    stable_d = stable_q;
    cnt_d    = cnt_q;
    prev_d   = stable_q;
    if (resync_i) begin
      stable_d = det_in;
      prev_d   = det_in;
      cnt_d    = '0;
    end else if (det_in == stable_q) begin
      cnt_d = '0;
    end else if (({1'b0, cnt_q} + 1'b1) >= {1'b0, cfg_i.filt}) begin
      stable_d = det_in;
      cnt_d    = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stable_q <= 1'b0;
      prev_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      stable_q <= stable_d;
      prev_q   <= prev_d;
      cnt_q    <= cnt_d;
    end
  end

  assign pulse = stable_q & ~prev_q;
  assign irq_o = cfg_i.edge_md ? pulse : stable_q;

  // R5: an edge indication never lasts more than one clock
  p_pulse_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse |=> !pulse);

  // R6: the filtered level only ever takes the value the input presented
  p_filter_source_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stable_q != $past(stable_q)) |-> (stable_q == $past(det_in)));

  // R7: reloading history after reconfiguration yields no edge
  p_resync_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_i |=> !pulse);
endmodule

// File: rtl/gpio_irq_mux.sv
module gpio_irq_mux
  import gim_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int NUM_PADS = 256
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PADS-1:0] pad_i,
  input  logic                wr_en_i,
  input  logic [1:0]          addr_i,
  input  logic [31:0]         wdata_i,
  input  logic [3:0]          be_i,
  output logic [31:0]         rdata_o,
  output logic [NUM_CH-1:0]   irq_o
);
  logic [NUM_PADS-1:0] pads_sync;
  chan_cfg_t           cfg [NUM_CH];
  logic [NUM_CH-1:0]   chg;

  gim_sync #(.W(NUM_PADS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_i),
    .q_o    (pads_sync)
  );

  gim_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .be_i    (be_i),
    .rdata_o (rdata_o),
    .cfg_o   (cfg),
    .chg_o   (chg)
  );

  for (genvar x = 0; x < NUM_CH; x++) begin : g_chan
    gim_channel #(.NUM_PADS(NUM_PADS)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pads_i   (pads_sync),
      .cfg_i    (cfg[x]),
      .resync_i (chg[x]),
      .irq_o    (irq_o[x])
    );
  end
endmodule

// File: tb/gpio_irq_mux_tb.sv
`timescale 1ns/1ps
module gpio_irq_mux_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] pad = '0;
  logic         we = 1'b0;
  logic [1:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [3:0]   be = '0;
  logic [31:0]  rdata;
  logic [7:0]   irq;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_mux u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pad_i(pad), .wr_en_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk); we = 1'b1; addr = a; wdata = d; be = b;
    @(negedge clk); we = 1'b0; be = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic watch(input int ch, input int n, output int first, output int cnt);
    first = 0; cnt = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (irq[ch]) begin
        cnt++;
        if (first == 0) first = k;
      end
    end
  endtask

  function automatic int padof(input int ch);
    return (ch * 37 + 5) % 256;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] lo, hi;
    int f, c, f2, c2;
    int nlist [5] = '{0, 1, 2, 5, 15};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle(2);

    // R1: reset state
    chk(irq == 8'h00, "R1 irq", {24'b0, irq}, 32'h0);
    for (int w = 0; w < 4; w++) begin
      rd(w[1:0], v);
      chk(v == 32'h0, "R1 word", v, 32'h0);
    end

    // R2: byte enables and full-word readback
    wr(2'd0, 32'hffff_ffff, 4'b0101);
    rd(2'd0, v); chk(v == 32'h00ff_00ff, "R2 mode be", v, 32'h00ff_00ff);
    wr(2'd0, 32'h0, 4'hf);
    rd(2'd0, v); chk(v == 32'h0, "R2 mode clear", v, 32'h0);
    wr(2'd3, 32'h1234_5678, 4'b1000);
    rd(2'd3, v); chk(v == 32'h1200_0000, "R2 filt be", v, 32'h1200_0000);
    wr(2'd3, 32'h0, 4'hf);
    settle(4);

    // R3: every index through channel 0
    for (int i = 0; i < 256; i++) begin
      wr(2'd1, i, 4'b0001);
      pad[i] = 1'b1; settle(3);
      chk(irq[0] == 1'b1, "R3 sweep high", {31'b0, irq[0]}, 32'h1);
      pad[i] = 1'b0; settle(3);
      chk(irq[0] == 1'b0, "R3 sweep low", {31'b0, irq[0]}, 32'h0);
    end

    // R3: distinct pads on all eight channels
    lo = '0; hi = '0;
    for (int ch = 0; ch < 4; ch++) lo |= padof(ch) << (8 * ch);
    for (int ch = 4; ch < 8; ch++) hi |= padof(ch) << (8 * (ch - 4));
    wr(2'd1, lo, 4'hf);
    wr(2'd2, hi, 4'hf);
    rd(2'd2, v); chk(v == hi, "R2 idx hi readback", v, hi);
    settle(4);
    for (int ch = 0; ch < 8; ch++) begin
      pad[padof(ch)] = 1'b1; settle(3);
      chk(irq == (8'h1 << ch), "R3 channel routing", {24'b0, irq}, 32'h1 << ch);
      pad[padof(ch)] = 1'b0; settle(3);
      chk(irq == 8'h0, "R3 channel release", {24'b0, irq}, 32'h0);
      pad[(padof(ch) + 1) % 256] = 1'b1; settle(3);
      chk(irq == 8'h0, "R3 neighbour pad", {24'b0, irq}, 32'h0);
      pad[(padof(ch) + 1) % 256] = 1'b0; settle(3);
    end

    // R4: inversion in level mode on channel 0
    wr(2'd0, 32'h0001_0000, 4'hf); settle(3);
    chk(irq[0] == 1'b1, "R4 inverted low pad", {31'b0, irq[0]}, 32'h1);
    chk(irq[7:1] == 7'h0, "R4 others unaffected", {25'b0, irq[7:1]}, 32'h0);
    pad[padof(0)] = 1'b1; settle(3);
    chk(irq[0] == 1'b0, "R4 inverted high pad", {31'b0, irq[0]}, 32'h0);
    pad[padof(0)] = 1'b0;
    wr(2'd0, 32'h0, 4'hf); settle(5);

    // R5: edge mode on channel 1
    wr(2'd0, 32'h0000_0002, 4'hf); settle(5);
    pad[padof(1)] = 1'b1; watch(1, 8, f, c);
    chk(f == 3, "R5 rise pulse time", f, 3);
    chk(c == 1, "R5 rise pulse width", c, 1);
    pad[padof(1)] = 1'b0; watch(1, 8, f, c);
    chk(c == 0, "R5 fall no pulse", c, 0);
    wr(2'd0, 32'h0002_0002, 4'hf); settle(5);
    chk(irq[1] == 1'b0, "R5 inverted idle", {31'b0, irq[1]}, 32'h0);
    pad[padof(1)] = 1'b1; watch(1, 8, f, c);
    chk(c == 0, "R5 inverted rise no pulse", c, 0);
    pad[padof(1)] = 1'b0; watch(1, 8, f, c);
    chk(f == 3, "R5 inverted fall time", f, 3);
    chk(c == 1, "R5 inverted fall width", c, 1);
    // edge mode behind a depth-3 filter
    wr(2'd0, 32'h0000_0002, 4'hf);
    wr(2'd3, 32'h0000_0030, 4'hf); settle(5);
    pad[padof(1)] = 1'b1; watch(1, 10, f, c);
    chk(f == 5, "R5 R6 filtered edge time", f, 5);
    chk(c == 1, "R5 filtered edge width", c, 1);
    pad[padof(1)] = 1'b0;
    wr(2'd3, 32'h0, 4'hf);
    wr(2'd0, 32'h0, 4'hf); settle(8);

    // R6: filter latency on channel 2
    foreach (nlist[j]) begin
      wr(2'd3, nlist[j] << 8, 4'hf); settle(20);
      pad[padof(2)] = 1'b1; watch(2, 24, f, c);
      chk(f == ((nlist[j] > 1 ? nlist[j] : 1) + 2), "R6 latency", f,
          (nlist[j] > 1 ? nlist[j] : 1) + 2);
      pad[padof(2)] = 1'b0; settle(24);
      chk(irq[2] == 1'b0, "R6 release", {31'b0, irq[2]}, 32'h0);
    end
    // R6: glitch one shorter than depth 5 is dropped, depth-long passes
    wr(2'd3, 32'h0000_0500, 4'hf); settle(10);
    pad[padof(2)] = 1'b1; watch(2, 4, f, c);
    pad[padof(2)] = 1'b0; watch(2, 30, f2, c2);
    chk((c + c2) == 0, "R6 short glitch", c + c2, 0);
    pad[padof(2)] = 1'b1; watch(2, 5, f, c);
    pad[padof(2)] = 1'b0; watch(2, 30, f2, c2);
    chk((c + c2) > 0, "R6 full-length pulse", c + c2, 1);
    wr(2'd3, 32'h0, 4'hf); settle(8);

    // R7: switching an edge channel onto an already-high pad
    wr(2'd0, 32'h0000_0008, 4'hf); settle(5);
    pad[200] = 1'b1; settle(5);
    wr(2'd1, 32'd200 << 24, 4'b1000);
    watch(3, 10, f, c);
    chk(c == 0, "R7 no pulse on reselect", c, 0);
    pad[200] = 1'b0; settle(5);
    pad[200] = 1'b1; watch(3, 8, f, c);
    chk(c == 1, "R7 later edge still seen", c, 1);
    // R7: toggling inversion on an edge channel
    wr(2'd0, 32'h0000_0008, 4'hf); settle(5);
    pad[200] = 1'b0; settle(5);
    wr(2'd0, 32'h0008_0008, 4'hf);
    watch(3, 10, f, c);
    chk(c == 0, "R7 no pulse on inversion change", c, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule